// File: doc/BRIEF.md
# Serial Gain Register with Fast-Attack Offset

This block holds the gain setting of a variable-gain amplifier front end and is loaded over a 3-wire serial port: an active-low select, a serial clock and a data line. Every write frame is 24 bits long and is sent most significant bit first. The first bit is the read/write flag. The next 15 bits are a register address, and the last 8 bits are the data. The block stores the setting only for a complete write frame aimed at address 0x100. The stored byte splits into a 6-bit gain code and a 2-bit fast-attack step code.

A separate fast-attack input lowers the effective gain by the selected step while it is high. When that input drops, the gain returns to the programmed value without any new write. An enable input chooses between normal operation and a low-power sleep state. All serial, fast-attack and enable inputs are resynchronised into the system clock domain through two flops each. Outputs give the programmed gain code, the active fast-attack offset in dB, the resulting effective gain request and a sleep flag.

Top module: `vga_gain_ctrl`

## Requirements
- R1: After reset the programmed gain code, the fast-attack step code, the offset output and the effective gain output are all 0.
- R2: A frame is sampled on rising serial clock edges while the select line is low, MSB first, and takes effect at the rising edge of the select line. The layout is: bit 23 = read/write flag (0 = write), bits 22..8 = address, bits 7..0 = data. It is stored only when the address is 0x100.
- R3: Of the data byte, bits 7..2 (the first six received) become the gain code and bits 1..0 (the last two) become the fast-attack step code.
- R4: While the fast-attack input is high, the offset output equals 2, 4, 8 or 16 dB for step codes 0, 1, 2 or 3. While the input is low, the offset output is 0.
- R5: The effective gain output equals the gain code minus the offset, clamped at 0.
- R6: When the fast-attack input returns low, the effective gain returns to the programmed gain code with no new frame.
- R7: A frame whose read/write flag is 1 leaves the stored setting unchanged.
- R8: A write frame to any address other than 0x100 leaves the stored setting unchanged.
- R9: A frame with a serial clock count other than exactly 24 leaves the stored setting unchanged.
- R10: The sleep output is the inverse of the enable input. The stored setting is kept across a sleep period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_sdata | input | 1 | Serial data in |
| fast_atk_i | input | 1 | Fast-attack request |
| enable_i | input | 1 | High = operate, low = sleep |
| gain_code_o | output | 6 | Programmed gain code |
| fa_db_o | output | 5 | Active fast-attack offset in dB |
| eff_gain_o | output | 6 | Gain request after offset |
| sleep_o | output | 1 | Sleep state flag |

## Verification
The assertions take two things for granted. First, the serial clock and the select line change slowly compared with the system clock, so each level lasts at least three system cycles and survives the synchroniser. Second, the data line is stable around each sampling edge. The bench holds each serial clock phase for four system cycles and changes data only while the serial clock is low, several cycles before the rising edge. The fast-attack and enable inputs are also driven on the falling system clock edge and held for several cycles, so every level reaches the outputs.

// File: rtl/vgc_pkg.sv
package vgc_pkg;
  localparam int FRAME_W  = 24;
  localparam int ADDR_W   = 15;
  localparam int DATA_W   = 8;
  localparam int GAIN_W   = 6;
  localparam int STEP_W   = DATA_W - GAIN_W;
  localparam int FA_DB_W  = (1 << STEP_W) + 1;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [ADDR_W-1:0] GAIN_REG_ADDR = 15'h100;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [STEP_W-1:0] step;
  } gain_setting_t;

  function automatic logic [FA_DB_W-1:0] step_to_db(input logic [STEP_W-1:0] code);
    step_to_db = FA_DB_W'(2) << code;
  endfunction
endpackage

// File: rtl/vgc_sync.sv
module vgc_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      hold_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/vgc_spi_rx.sv
module vgc_spi_rx
  import vgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              commit_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic               sclk_q, cs_q;
  logic [FRAME_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               sclk_rise, cs_rise;
  logic               rw_bit;
  logic [ADDR_W-1:0]  addr_f;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign cs_rise   = cs_n_s & ~cs_q;
  assign rw_bit    = shift_q[FRAME_W-1];
  assign addr_f    = shift_q[FRAME_W-2 -: ADDR_W];

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    if (cs_n_s) begin
      cnt_n = '0;
    end else if (sclk_rise) begin
      shift_n = {shift_q[FRAME_W-2:0], sdata_s};
      if (cnt_q != CNT_SAT) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk_s;
      cs_q    <= cs_n_s;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
    end
  end

  assign commit_o = cs_rise && (cnt_q == CNT_FULL) && !rw_bit && (addr_f == GAIN_REG_ADDR);
  assign data_o   = shift_q[DATA_W-1:0];
endmodule

// File: rtl/vgc_gain_core.sv
module vgc_gain_core
  import vgc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               fa_s,
  input  logic               en_s,
  output logic [GAIN_W-1:0]  gain_code_o,
  output logic [FA_DB_W-1:0] fa_db_o,
  output logic [GAIN_W-1:0]  eff_gain_o,
  output logic               sleep_o
);
  gain_setting_t set_q, set_n;
  logic [GAIN_W:0] diff;

  always_comb begin
    set_n = set_q;
    if (commit_i) set_n = gain_setting_t'(data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= '0;
    else        set_q <= set_n;
  end

  assign gain_code_o = set_q.gain;
  assign fa_db_o     = fa_s ? step_to_db(set_q.step) : '0;
  assign diff        = {1'b0, set_q.gain} - (GAIN_W+1)'(fa_db_o);
  assign eff_gain_o  = diff[GAIN_W] ? '0 : diff[GAIN_W-1:0];
  assign sleep_o     = ~en_s;
endmodule

// File: rtl/vga_gain_ctrl.sv
module vga_gain_ctrl
  import vgc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spi_cs_n,
  input  logic               spi_sclk,
  input  logic               spi_sdata,
  input  logic               fast_atk_i,
  input  logic               enable_i,
  output logic [GAIN_W-1:0]  gain_code_o,
  output logic [FA_DB_W-1:0] fa_db_o,
  output logic [GAIN_W-1:0]  eff_gain_o,
  output logic               sleep_o
);
  logic       rst_n_int;
  logic [1:0] rst_pipe_q;
  logic [4:0] in_s;
  logic       commit_w;
  logic [DATA_W-1:0] data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  vgc_sync #(.W(5), .RST_VAL(5'b00001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   ({enable_i, fast_atk_i, spi_sdata, spi_sclk, spi_cs_n}),
    .q_o   (in_s)
  );

  vgc_spi_rx u_rx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cs_n_s   (in_s[0]),
    .sclk_s   (in_s[1]),
    .sdata_s  (in_s[2]),
    .commit_o (commit_w),
    .data_o   (data_w)
  );

  vgc_gain_core u_core (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .commit_i    (commit_w),
    .data_i      (data_w),
    .fa_s        (in_s[3]),
    .en_s        (in_s[4]),
    .gain_code_o (gain_code_o),
    .fa_db_o     (fa_db_o),
    .eff_gain_o  (eff_gain_o),
    .sleep_o     (sleep_o)
  );
endmodule

// File: rtl/vga_gain_ctrl_chk.sv
module vga_gain_ctrl_chk
  import vgc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               fast_atk_i,
  input logic               commit_w,
  input logic [GAIN_W-1:0]  gain_code_o,
  input logic [FA_DB_W-1:0] fa_db_o,
  input logic [GAIN_W-1:0]  eff_gain_o
);
  a_r4_offset_legal: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fa_db_o) <= 1) && !fa_db_o[0]);

  a_r4_offset_zero_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fast_atk_i, 2) |-> (fa_db_o == '0));

  a_r5_eff_not_above_gain: assert property (@(posedge clk) disable iff (!rst_n)
    eff_gain_o <= gain_code_o);

  a_r6_no_offset_full_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_db_o == '0) |-> (eff_gain_o == gain_code_o));

  a_r7_setting_held_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_w |=> $stable(gain_code_o));
endmodule

bind vga_gain_ctrl vga_gain_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fast_atk_i  (fast_atk_i),
  .commit_w    (commit_w),
  .gain_code_o (gain_code_o),
  .fa_db_o     (fa_db_o),
  .eff_gain_o  (eff_gain_o)
);

// File: tb/vga_gain_ctrl_tb_top.sv
`timescale 1ns/1ps
module vga_gain_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0, fa = 1'b0, en = 1'b1;
  logic [5:0] gain_code;
  logic [4:0] fa_db;
  logic [5:0] eff_gain;
  logic       sleep;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vga_gain_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdata(sdata),
    .fast_atk_i(fa), .enable_i(en), .gain_code_o(gain_code), .fa_db_o(fa_db),
    .eff_gain_o(eff_gain), .sleep_o(sleep)
  );

  // vector: gain[19:14], step[13:12], fa pin[11], expected dB[10:6], expected eff[5:0]
  localparam logic [19:0] VEC [0:7] = '{
    {6'd40, 2'd0, 1'b1, 5'd2,  6'd38},
    {6'd40, 2'd3, 1'b1, 5'd16, 6'd24},
    {6'd10, 2'd3, 1'b1, 5'd16, 6'd0},
    {6'd63, 2'd2, 1'b0, 5'd0,  6'd63},
    {6'd63, 2'd2, 1'b1, 5'd8,  6'd55},
    {6'd5,  2'd1, 1'b1, 5'd4,  6'd1},
    {6'd16, 2'd3, 1'b1, 5'd16, 6'd0},
    {6'd0,  2'd0, 1'b0, 5'd0,  6'd0}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic spi_send(input logic [31:0] bits, input int nbits);
    wait_clk(1);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = bits[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(8);
  endtask

  function automatic logic [31:0] frame(input logic rw, input logic [14:0] addr,
                                        input logic [5:0] g, input logic [1:0] s);
    return {8'h00, rw, addr, g, s};
  endfunction

  task automatic set_fa(input logic v);
    fa = v;
    wait_clk(5);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(8);
    // R1 reset values
    chk("R1 gain", gain_code, 0);
    chk("R1 offset", fa_db, 0);
    chk("R1 eff", eff_gain, 0);
    chk("R10 awake", sleep, 0);
    set_fa(1'b1);
    chk("R1 step code 0 gives 2 dB", fa_db, 2);
    set_fa(1'b0);

    // table: R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      spi_send(frame(1'b0, 15'h100, VEC[k][19:14], VEC[k][13:12]), 24);
      set_fa(VEC[k][11]);
      chk("R2/R3 gain", gain_code, VEC[k][19:14]);
      chk("R4 offset", fa_db, VEC[k][10:6]);
      chk("R5 eff", eff_gain, VEC[k][5:0]);
    end

    // R6 release
    spi_send(frame(1'b0, 15'h100, 6'd30, 2'd2), 24);
    set_fa(1'b1);
    chk("R6 offset while high", eff_gain, 22);
    set_fa(1'b0);
    chk("R6 eff after release", eff_gain, 30);
    chk("R6 offset after release", fa_db, 0);

    // R7 read ignored
    spi_send(frame(1'b1, 15'h100, 6'd12, 2'd1), 24);
    chk("R7 gain unchanged", gain_code, 30);
    set_fa(1'b1);
    chk("R7 step unchanged", fa_db, 8);
    set_fa(1'b0);

    // R8 other addresses
    spi_send(frame(1'b0, 15'h101, 6'd12, 2'd1), 24);
    chk("R8 addr 0x101", gain_code, 30);
    spi_send(frame(1'b0, 15'h000, 6'd12, 2'd1), 24);
    chk("R8 addr 0x000", gain_code, 30);

    // R9 wrong counts
    spi_send(frame(1'b0, 15'h100, 6'd12, 2'd1) >> 1, 23);
    chk("R9 23 clocks", gain_code, 30);
    spi_send({frame(1'b0, 15'h100, 6'd12, 2'd1), 1'b0}, 25);
    chk("R9 25 clocks", gain_code, 30);
    spi_send(frame(1'b0, 15'h100, 6'd12, 2'd1), 24);
    chk("R9 exact 24 accepted", gain_code, 12);

    // R10 sleep
    en = 1'b0;
    wait_clk(5);
    chk("R10 sleep", sleep, 1);
    wait_clk(20);
    en = 1'b1;
    wait_clk(5);
    chk("R10 wake", sleep, 0);
    chk("R10 setting kept", gain_code, 12);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule